// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt events for a small microcontroller core from four sources: a programmable timer, a data-ready event from a message decoder, a timer/event counter and a low-battery detector. The data-ready and low-battery sources share one service channel and one vector. The timer and the counter each have a channel of their own. A control register holds a global enable bit, one enable bit per channel and one request flag per channel. A separate status register has two active-low bits, so the service routine on the shared vector can tell which of its two sources fired.

When the global enable is set, an enabled channel is pending and the return stack is not full, the block pulses a push strobe for one cycle and presents the vector address of the highest-priority pending channel. The program counter and stack logic outside the block save the program counter and branch to that vector. Nothing else is saved. On that same clock edge the block clears the global enable and the request flag of the channel that was taken, so that nesting is blocked. Requests that arrive later only set their flags. Software may set the global enable again inside a service routine to allow nesting. A separate wake-up output tells a halted core that an enabled request is pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x90, and push and wake are low. Control bit 7 always reads 0, even after a write of 0x80.
- R2: Control register layout: bit 0 is the global enable. Bits 1, 2 and 3 enable the shared, timer and counter channels. Bits 4, 5 and 6 are their request flags. A data-ready or low-battery event sets bit 4, a timer event sets bit 5 and a counter event sets bit 6. The flag appears one edge after the event, whatever the enables are.
- R3: Push is high in any cycle in which the global enable is set, some channel has both its enable and its flag set, and stack-full is low. The vector is 0x04 for the shared channel, 0x08 for the timer and 0x0C for the counter.
- R4: When several channels are pending, the shared channel wins over the timer, and the timer wins over the counter.
- R5: At the edge that ends a push cycle, the global enable clears and the taken channel's flag clears. The other bits are kept, so push lasts exactly one cycle.
- R6: While the global enable is clear, requests only set their flags and push stays low.
- R7: A software write that sets the global enable again while other channels are pending raises push for the next channel in priority order.
- R8: While stack-full is high, push stays low. Push rises in the same cycle that stack-full falls.
- R9: Wake is high whenever some channel has both its enable and its flag set, regardless of the global enable and of stack-full.
- R10: Status bit 7 (data-ready) and status bit 4 (low-battery) are active low. Each clears one edge after its event. A software write loads both bits from the written data. All other status bits read 0.
- R11: An event wins over a software write in the same cycle, and over the flag clear of a push in the same cycle: the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_drdy_i | input | 1 | Data-ready event from decoder, one pulse per event |
| ev_bfail_i | input | 1 | Low-battery event |
| ev_timer_i | input | 1 | Programmable timer event |
| ev_tec_i | input | 1 | Timer/event counter event |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status register write data |
| stat_rdata_o | output | 8 | Status register contents |
| stack_full_i | input | 1 | Return stack has no free entry |
| push_o | output | 1 | Take interrupt: push program counter and branch |
| vec_o | output | 8 | Vector address while push is high, otherwise 0 |
| wake_o | output | 1 | Enabled request pending, wake a halted core |

## Verification
Register results (flags, enables, status bits) appear one rising edge after the event or write that causes them. Push, vector and wake are combinational from those registers and from stack-full, so they are valid in the cycle the register changes. The bench drives every input just after a falling edge. It checks register results at the next falling edge, after exactly one rising edge. It checks push, vector and wake one time step after their cause settles, which is before the rising edge that ends a push. The post-push clear is then read at the following falling edge.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Channel indices; lower index means higher priority.
    localparam int unsigned CH_SHARED = 0;
    localparam int unsigned CH_TIMER  = 1;
    localparam int unsigned CH_TEC    = 2;
    localparam int unsigned NUM_SRC_CH = 3;

    // Active-low source status bits for the shared vector.
    typedef struct packed {
        logic drdy_n;
        logic bfail_n;
    } stat_t;

endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 4,
    parameter int unsigned VEC_STEP = 4
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic              any_o,
    output logic [NUM_CH-1:0] gnt_o,
    output logic [VEC_W-1:0]  vec_o
);

    // blk[i] is high when some lower-index channel requests.
    logic [NUM_CH:0] blk;
    assign blk[0] = 1'b0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
        assign gnt_o[i]  = req_i[i] & ~blk[i];
        assign blk[i+1]  = blk[i] | req_i[i];
    end

    assign any_o = blk[NUM_CH];

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (gnt_o[i]) vec_o = VEC_W'(VEC_BASE + i * VEC_STEP);
        end
    end

endmodule

// File: rtl/pic_status.sv
module pic_status
    import pic_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DRDY_BIT  = 7,
    parameter int unsigned BFAIL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_ev_i,
    input  logic              bfail_ev_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    stat_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.drdy_n  = wdata_i[DRDY_BIT];
            st_d.bfail_n = wdata_i[BFAIL_BIT];
        end
        if (drdy_ev_i)  st_d.drdy_n  = 1'b0;
        if (bfail_ev_i) st_d.bfail_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o            = '0;
        rdata_o[DRDY_BIT]  = st_q.drdy_n;
        rdata_o[BFAIL_BIT] = st_q.bfail_n;
    end

    // R10: a low-battery event drives its status bit low at the next edge
    a_r10_bfail_low: assert property (@(posedge clk) disable iff (!rst_n)
        bfail_ev_i |=> !rdata_o[BFAIL_BIT]);

    // R10: a data-ready event drives its status bit low at the next edge
    a_r10_drdy_low: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_ev_i |=> !rdata_o[DRDY_BIT]);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_CH    = NUM_SRC_CH,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned VEC_BASE  = 4,
    parameter int unsigned VEC_STEP  = 4,
    parameter int unsigned DRDY_BIT  = 7,
    parameter int unsigned BFAIL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_drdy_i,
    input  logic              ev_bfail_i,
    input  logic              ev_timer_i,
    input  logic              ev_tec_i,
    input  logic              ctl_we_i,
    input  logic [DATA_W-1:0] ctl_wdata_i,
    output logic [DATA_W-1:0] ctl_rdata_o,
    input  logic              stat_we_i,
    input  logic [DATA_W-1:0] stat_wdata_i,
    output logic [DATA_W-1:0] stat_rdata_o,
    input  logic              stack_full_i,
    output logic              push_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              wake_o
);

    localparam int unsigned EN_LSB  = 1;
    localparam int unsigned FLG_LSB = EN_LSB + NUM_CH;

    typedef struct packed {
        logic              mstr;
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] flag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CH-1:0] ch_ev;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] gnt;
    logic [VEC_W-1:0]  sel_vec;
    logic              any_pend;
    logic              take;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^ctl_wdata_i;

    // Map sources onto channels; two sources share the first channel.
    always_comb begin
        ch_ev            = '0;
        ch_ev[CH_SHARED] = ev_drdy_i | ev_bfail_i;
        ch_ev[CH_TIMER]  = ev_timer_i;
        ch_ev[CH_TEC]    = ev_tec_i;
    end

    assign pend = ctl_q.en & ctl_q.flag;

    pic_prio #(
        .NUM_CH   (NUM_CH),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) prio_i (
        .req_i (pend),
        .any_o (any_pend),
        .gnt_o (gnt),
        .vec_o (sel_vec)
    );

    assign take   = ctl_q.mstr & any_pend & ~stack_full_i;
    assign push_o = take;
    assign vec_o  = take ? sel_vec : '0;
    assign wake_o = any_pend;

    // Next state: software write, then entry clear, then event set.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we_i) begin
            ctl_d.mstr = ctl_wdata_i[0];
            ctl_d.en   = ctl_wdata_i[EN_LSB +: NUM_CH];
            ctl_d.flag = ctl_wdata_i[FLG_LSB +: NUM_CH];
        end
        if (take) begin
            ctl_d.mstr = 1'b0;
            ctl_d.flag = ctl_d.flag & ~gnt;
        end
        ctl_d.flag = ctl_d.flag | ch_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_rdata_o                     = '0;
        ctl_rdata_o[0]                  = ctl_q.mstr;
        ctl_rdata_o[EN_LSB +: NUM_CH]   = ctl_q.en;
        ctl_rdata_o[FLG_LSB +: NUM_CH]  = ctl_q.flag;
    end

    pic_status #(
        .DATA_W    (DATA_W),
        .DRDY_BIT  (DRDY_BIT),
        .BFAIL_BIT (BFAIL_BIT)
    ) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_ev_i  (ev_drdy_i),
        .bfail_ev_i (ev_bfail_i),
        .we_i       (stat_we_i),
        .wdata_i    (stat_wdata_i),
        .rdata_o    (stat_rdata_o)
    );

    // R5: entry clears the global enable at the next edge
    a_r5_mstr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !ctl_rdata_o[0]);

    // R5: push never lasts two cycles
    a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    // R8: a full stack blocks entry
    a_r8_stack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full_i |-> !push_o);

    // R6: no entry while the global enable reads clear
    a_r6_master_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata_o[0] |-> !push_o);

    // R2, R11: a timer event always leaves its flag set
    a_r2_timer_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timer_i |=> ctl_rdata_o[FLG_LSB + CH_TIMER]);

    // R9: every entry is also a wake-up condition
    a_r9_wake_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> wake_o);

    // R4: a pending shared channel always owns the vector
    a_r4_shared_first: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && ctl_rdata_o[EN_LSB + CH_SHARED] && ctl_rdata_o[FLG_LSB + CH_SHARED])
        |-> (vec_o == VEC_W'(VEC_BASE)));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_drdy = 1'b0, ev_bfail = 1'b0, ev_timer = 1'b0, ev_tec = 1'b0;
    logic       ctl_we = 1'b0, stat_we = 1'b0;
    logic [7:0] ctl_wd = '0, stat_wd = '0;
    logic [7:0] ctl_rd, stat_rd, vec;
    logic       stack_full = 1'b0;
    logic       push, wake;

    int n_cmp = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_drdy_i    (ev_drdy),
        .ev_bfail_i   (ev_bfail),
        .ev_timer_i   (ev_timer),
        .ev_tec_i     (ev_tec),
        .ctl_we_i     (ctl_we),
        .ctl_wdata_i  (ctl_wd),
        .ctl_rdata_o  (ctl_rd),
        .stat_we_i    (stat_we),
        .stat_wdata_i (stat_wd),
        .stat_rdata_o (stat_rd),
        .stack_full_i (stack_full),
        .push_o       (push),
        .vec_o        (vec),
        .wake_o       (wake)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    // All drivers start just after a falling edge and return one step after the next one.
    task automatic idle();
        @(negedge clk); #1;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wd = d;
        @(negedge clk); ctl_we = 1'b0; #1;
    endtask

    task automatic wr_stat(input logic [7:0] d);
        stat_we = 1'b1; stat_wd = d;
        @(negedge clk); stat_we = 1'b0; #1;
    endtask

    // m = {tec, timer, bfail, drdy}
    task automatic pulse(input logic [3:0] m);
        {ev_tec, ev_timer, ev_bfail, ev_drdy} = m;
        @(negedge clk); {ev_tec, ev_timer, ev_bfail, ev_drdy} = '0; #1;
    endtask

    task automatic t_reset();
        chk("R1", "ctl", ctl_rd, 8'h00);
        chk("R1", "stat", stat_rd, 8'h90);
        chk("R1", "push", {7'b0, push}, 8'h00);
        chk("R1", "wake", {7'b0, wake}, 8'h00);
        wr_ctl(8'h80);
        chk("R1", "ctl bit7", ctl_rd, 8'h00);
    endtask

    task automatic t_latch();
        pulse(4'b0100);
        chk("R2", "timer flag", ctl_rd, 8'h20);
        chk("R6", "push", {7'b0, push}, 8'h00);
        chk("R9", "wake disabled", {7'b0, wake}, 8'h00);
        wr_ctl(8'h24);
        chk("R9", "wake no master", {7'b0, wake}, 8'h01);
        chk("R6", "push no master", {7'b0, push}, 8'h00);
        pulse(4'b1000);
        chk("R2", "counter flag", ctl_rd, 8'h64);
    endtask

    task automatic t_prio();
        wr_ctl(8'h7F);
        chk("R3", "push", {7'b0, push}, 8'h01);
        chk("R4", "vec shared", vec, 8'h04);
        idle();
        chk("R5", "ctl after", ctl_rd, 8'h6E);
        chk("R5", "push once", {7'b0, push}, 8'h00);
        wr_ctl(8'h6F);
        chk("R7", "push renest", {7'b0, push}, 8'h01);
        chk("R4", "vec timer", vec, 8'h08);
        idle();
        chk("R5", "ctl after timer", ctl_rd, 8'h4E);
        wr_ctl(8'h4F);
        chk("R3", "vec counter", vec, 8'h0C);
        idle();
        chk("R5", "ctl after counter", ctl_rd, 8'h0E);
        chk("R9", "wake none", {7'b0, wake}, 8'h00);
    endtask

    task automatic t_stack();
        stack_full = 1'b1;
        wr_ctl(8'h25);
        chk("R8", "push blocked", {7'b0, push}, 8'h00);
        chk("R9", "wake stack full", {7'b0, wake}, 8'h01);
        idle();
        chk("R8", "ctl held", ctl_rd, 8'h25);
        stack_full = 1'b0; #1;
        chk("R8", "push resumes", {7'b0, push}, 8'h01);
        chk("R8", "vec", vec, 8'h08);
        idle();
        chk("R8", "ctl after", ctl_rd, 8'h04);
    endtask

    task automatic t_shared();
        wr_ctl(8'h00);
        pulse(4'b0010);
        chk("R10", "stat bfail", stat_rd, 8'h80);
        chk("R2", "shared flag", ctl_rd, 8'h10);
        wr_stat(8'h90);
        chk("R10", "stat restore", stat_rd, 8'h90);
        pulse(4'b0001);
        chk("R10", "stat drdy", stat_rd, 8'h10);
        wr_stat(8'hFF);
        chk("R10", "stat others zero", stat_rd, 8'h90);
        wr_ctl(8'h13);
        chk("R3", "vec shared", vec, 8'h04);
        idle();
        chk("R5", "ctl after", ctl_rd, 8'h02);
    endtask

    task automatic t_coincide();
        ctl_we = 1'b1; ctl_wd = 8'h00; ev_tec = 1'b1;
        @(negedge clk); ctl_we = 1'b0; ev_tec = 1'b0; #1;
        chk("R11", "event over write", ctl_rd, 8'h40);
        wr_ctl(8'h25);
        chk("R11", "push", {7'b0, push}, 8'h01);
        pulse(4'b0100);
        chk("R11", "event over clear", ctl_rd, 8'h24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        t_reset();
        t_latch();
        t_prio();
        t_stack();
        t_shared();
        t_coincide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule